// File: doc/BRIEF.md
# Four-Valued Switch-Level Evaluator

This block evaluates switch-level circuit primitives over a four-valued signal domain: driven high, driven low, floating, and unknown. Each lane holds a P-type switch, an N-type switch, a wire-join resolver, a NAND gate built from those switches and joins, and a clocked storage node that keeps its charge while its input floats. A select port picks which primitive drives the lane output. Every lane also reports whether that output is well defined, together with its Boolean reading.

Switches and joins are combinational and conduct in one direction only, from source to drain. Resolution follows a value lattice. Unknown sits at the top and floating at the bottom, so a driven value beats a floating one, and any conflict between driven values gives unknown. The storage node acts as a small two-state-plus-reset machine. It loads any non-floating input on the rising clock edge and holds otherwise. Lanes are independent and their count is a parameter.

The select codes are PSW (3'd0), NSW (3'd1), JOIN (3'd2), NAND (3'd3) and CELL (3'd4). The storage node's next-state rule has three named transitions. LOAD takes a driven or unknown input. HOLD keeps the old charge when the input floats. RESET forces unknown.

Top module: `sw_eval`

## Requirements
- R1: Each value is 2 bits: 2'b00 low, 2'b01 high, 2'b10 floating, 2'b11 unknown. Lane k occupies bits [2k+1:2k] of every packed vector.
- R2: With select JOIN, each lane outputs the least upper bound of a and b. Equal values give that value. Floating joined with x gives x. Any other mismatch gives unknown.
- R3: With select PSW (gate = a, source = b), the output is b when a is low, floating when a is high, and unknown for any other gate value.
- R4: With select NSW (gate = a, source = b), the output is b when a is high, floating when a is low, and unknown for any other gate value.
- R5: With select NAND and both inputs high or low, the output is the logical NAND, with high meaning 1.
- R6: With select NAND and either input floating or unknown, the output is unknown.
- R7: def_o is 1 exactly when the lane output is high or low. bit_o is 1 exactly when the lane output is high.
- R8: With select CELL, a non-floating a is stored at the rising clock edge. It appears on cell_o, and on y_o under CELL, after that edge.
- R9: The stored value is unchanged across an edge when the select is CELL and a is floating, or when the select is not CELL.
- R10: While rst_n is low, each stored value is unknown.
- R11: Select codes 5 to 7 drive unknown on every lane output.
- R12: Lanes are evaluated independently of each other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the storage nodes |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_sel | input | 3 | Primitive select |
| a_i | input | 2*LANES | Operand a per lane (switch gate, storage input) |
| b_i | input | 2*LANES | Operand b per lane (switch source) |
| y_o | output | 2*LANES | Selected primitive output per lane |
| def_o | output | LANES | Lane output is high or low |
| bit_o | output | LANES | Boolean reading of lane output |
| cell_o | output | 2*LANES | Stored value per lane |

## Verification
Every combinational primitive is driven through all sixteen pairs of operand values. Lane 1 receives the operands swapped, so asymmetric mistakes in the switches, such as swapping gate and source or inverting gate polarity, show up as a lane mismatch. Floating and unknown operands separate the lattice ordering from a plain equality test. They also separate the NAND's unknown case from its Boolean truth table. The storage node is walked from its reset value through a load, two kinds of hold (floating input and another select), and a load of unknown on one lane only. This tells a correct hold apart from an always-load or a reset-to-zero design.

// File: rtl/sw_pkg.sv
package sw_pkg;
    typedef enum logic [1:0] {
        SV_LO = 2'b00,
        SV_HI = 2'b01,
        SV_ZZ = 2'b10,
        SV_ER = 2'b11
    } sv_t;

    typedef enum logic [2:0] {
        OP_PSW  = 3'd0,
        OP_NSW  = 3'd1,
        OP_JOIN = 3'd2,
        OP_NAND = 3'd3,
        OP_CELL = 3'd4
    } op_t;
endpackage

// File: rtl/sw_switch.sv
module sw_switch
    import sw_pkg::*;
#(
    parameter bit PTYPE = 1'b0
) (
    input  sv_t gate_i,
    input  sv_t src_i,
    output sv_t drn_o
);
    localparam sv_t CONDUCT = PTYPE ? SV_LO : SV_HI;
    localparam sv_t BLOCK   = PTYPE ? SV_HI : SV_LO;

    always_comb begin
        if (gate_i == CONDUCT)
            drn_o = src_i;
        else if (gate_i == BLOCK)
            drn_o = SV_ZZ;
        else
            drn_o = SV_ER;
    end
endmodule

// File: rtl/sw_join.sv
module sw_join
    import sw_pkg::*;
(
    input  sv_t p_i,
    input  sv_t q_i,
    output sv_t r_o
);
    always_comb begin
        if (p_i == q_i)
            r_o = p_i;
        else if (p_i == SV_ZZ)
            r_o = q_i;
        else if (q_i == SV_ZZ)
            r_o = p_i;
        else
            r_o = SV_ER;
    end
endmodule

// File: rtl/sw_nand.sv
module sw_nand
    import sw_pkg::*;
(
    input  sv_t x_i,
    input  sv_t z_i,
    output sv_t o_o
);
    sv_t pu_x, pu_z, pu_mid, pd_low, pd_top;

    // pull-up pair from the supply rail
    sw_switch #(.PTYPE(1'b1)) u_pux (.gate_i(x_i), .src_i(SV_HI), .drn_o(pu_x));
    sw_switch #(.PTYPE(1'b1)) u_puz (.gate_i(z_i), .src_i(SV_HI), .drn_o(pu_z));
    // series pull-down stack from ground
    sw_switch #(.PTYPE(1'b0)) u_pdz (.gate_i(z_i), .src_i(SV_LO), .drn_o(pd_low));
    sw_switch #(.PTYPE(1'b0)) u_pdx (.gate_i(x_i), .src_i(pd_low), .drn_o(pd_top));

    sw_join u_j0 (.p_i(pu_x),   .q_i(pu_z),   .r_o(pu_mid));
    sw_join u_j1 (.p_i(pu_mid), .q_i(pd_top), .r_o(o_o));
endmodule

// File: rtl/sw_store.sv
module sw_store
    import sw_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  sv_t  d_i,
    output sv_t  q_o
);
    sv_t held, held_nxt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            held <= SV_ER;           // RESET transition
        else
            held <= held_nxt;
    end

    always_comb begin
        held_nxt = held;
        unique case (d_i)
            SV_ZZ:               held_nxt = held;   // HOLD
            SV_LO, SV_HI, SV_ER: held_nxt = d_i;    // LOAD
        endcase
    end

    assign q_o = held;

    a_r10_reset_er: assert property (@(posedge clk) $rose(rst_n) |-> q_o == SV_ER);
    a_r8_load: assert property (@(posedge clk) disable iff (!rst_n)
        d_i != SV_ZZ |=> q_o == $past(d_i));
    a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
        d_i == SV_ZZ |=> $stable(q_o));
endmodule

// File: rtl/sw_eval.sv
module sw_eval
    import sw_pkg::*;
#(
    parameter int LANES = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [2:0]         op_sel,
    input  logic [2*LANES-1:0] a_i,
    input  logic [2*LANES-1:0] b_i,
    output logic [2*LANES-1:0] y_o,
    output logic [LANES-1:0]   def_o,
    output logic [LANES-1:0]   bit_o,
    output logic [2*LANES-1:0] cell_o
);
    localparam int VW = 2 * LANES;

    op_t op;
    assign op = op_t'(op_sel);

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        sv_t a, b, p_out, n_out, j_out, n_and, st_d, st_q, y;

        assign a = sv_t'(a_i[2*l +: 2]);
        assign b = sv_t'(b_i[2*l +: 2]);

        sw_switch #(.PTYPE(1'b1)) u_p (.gate_i(a), .src_i(b), .drn_o(p_out));
        sw_switch #(.PTYPE(1'b0)) u_n (.gate_i(a), .src_i(b), .drn_o(n_out));
        sw_join                   u_j (.p_i(a), .q_i(b), .r_o(j_out));
        sw_nand                   u_g (.x_i(a), .z_i(b), .o_o(n_and));

        // storage input floats unless this primitive is selected
        assign st_d = (op == OP_CELL) ? a : SV_ZZ;
        sw_store u_s (.clk(clk), .rst_n(rst_n), .d_i(st_d), .q_o(st_q));

        always_comb begin
            case (op)
                OP_PSW:  y = p_out;
                OP_NSW:  y = n_out;
                OP_JOIN: y = j_out;
                OP_NAND: y = n_and;
                OP_CELL: y = st_q;
                default: y = SV_ER;
            endcase
        end

        assign y_o[2*l +: 2]    = y;
        assign cell_o[2*l +: 2] = st_q;
        assign def_o[l]         = (y == SV_LO) || (y == SV_HI);
        assign bit_o[l]         = (y == SV_HI);

        a_r5_nand_bool: assert property (@(posedge clk) disable iff (!rst_n)
            (op_sel == 3'd3 && a_i[2*l+1] == 1'b0 && b_i[2*l+1] == 1'b0)
            |-> (def_o[l] && bit_o[l] == !(a_i[2*l] && b_i[2*l])));
        a_r6_nand_er: assert property (@(posedge clk) disable iff (!rst_n)
            (op_sel == 3'd3 && (a_i[2*l+1] || b_i[2*l+1])) |-> y_o[2*l +: 2] == 2'b11);
        a_r2_join_float: assert property (@(posedge clk) disable iff (!rst_n)
            (op_sel == 3'd2 && a_i[2*l +: 2] == 2'b10) |-> y_o[2*l +: 2] == b_i[2*l +: 2]);
        a_r3_psw_open: assert property (@(posedge clk) disable iff (!rst_n)
            (op_sel == 3'd0 && a_i[2*l +: 2] == 2'b01) |-> y_o[2*l +: 2] == 2'b10);
        a_r4_nsw_open: assert property (@(posedge clk) disable iff (!rst_n)
            (op_sel == 3'd1 && a_i[2*l +: 2] == 2'b00) |-> y_o[2*l +: 2] == 2'b10);
    end

    a_r11_unused: assert property (@(posedge clk) disable iff (!rst_n)
        op_sel > 3'd4 |-> y_o == {VW{1'b1}});
endmodule

// File: tb/sim_sw_eval.sv
module sim_sw_eval;
    localparam int CLK_PER = 10;
    localparam int L = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [2:0] op_sel = 3'd0;
    logic [2*L-1:0] a_i = '0, b_i = '0;
    logic [2*L-1:0] y_o, cell_o;
    logic [L-1:0] def_o, bit_o;

    always #(CLK_PER/2) clk = ~clk;

    sw_eval #(.LANES(L)) u0 (.clk(clk), .rst_n(rst_n), .op_sel(op_sel), .a_i(a_i), .b_i(b_i),
        .y_o(y_o), .def_o(def_o), .bit_o(bit_o), .cell_o(cell_o));

    typedef struct {
        string          ytag;
        string          ctag;
        logic [2*L-1:0] y;
        logic [L-1:0]   d;
        logic [L-1:0]   b;
        logic [2*L-1:0] c;
    } item_t;

    item_t sb[$];
    int checks = 0, failures = 0;
    logic [2*L-1:0] model_cell = {L{2'b11}};   // R10: reset value unknown
    string ctag_g = "R10";
    bit done = 1'b0;

    // R1 encoding: 00 low, 01 high, 10 floating, 11 unknown
    function automatic logic [1:0] e_lub(logic [1:0] p, logic [1:0] q);
        if (p == q) return p;
        if (p == 2'b10) return q;
        if (q == 2'b10) return p;
        return 2'b11;
    endfunction
    function automatic logic [1:0] e_psw(logic [1:0] g, logic [1:0] s);
        return (g == 2'b00) ? s : (g == 2'b01) ? 2'b10 : 2'b11;
    endfunction
    function automatic logic [1:0] e_nsw(logic [1:0] g, logic [1:0] s);
        return (g == 2'b01) ? s : (g == 2'b00) ? 2'b10 : 2'b11;
    endfunction
    function automatic logic [1:0] e_nand(logic [1:0] p, logic [1:0] q);
        if (p[1] || q[1]) return 2'b11;
        return (p == 2'b01 && q == 2'b01) ? 2'b00 : 2'b01;
    endfunction

    task automatic step(input logic [2:0] op, input logic [2*L-1:0] av, input logic [2*L-1:0] bv);
        item_t it;
        @(negedge clk);
        op_sel = op; a_i = av; b_i = bv;
        it.c = model_cell;
        it.ctag = ctag_g;
        case (op)
            3'd0: it.ytag = "R3";
            3'd1: it.ytag = "R4";
            3'd2: it.ytag = "R2";
            3'd3: it.ytag = "R5/R6";
            3'd4: it.ytag = "R8";
            default: it.ytag = "R11";
        endcase
        for (int k = 0; k < L; k++) begin
            logic [1:0] x, z, r;
            x = av[2*k +: 2]; z = bv[2*k +: 2];
            case (op)
                3'd0: r = e_psw(x, z);
                3'd1: r = e_nsw(x, z);
                3'd2: r = e_lub(x, z);
                3'd3: r = e_nand(x, z);
                3'd4: r = model_cell[2*k +: 2];
                default: r = 2'b11;
            endcase
            it.y[2*k +: 2] = r;
            it.d[k] = (r == 2'b00) || (r == 2'b01);
            it.b[k] = (r == 2'b01);
        end
        sb.push_back(it);
        if (op == 3'd4)
            for (int k = 0; k < L; k++)
                if (av[2*k +: 2] != 2'b10) model_cell[2*k +: 2] = av[2*k +: 2];
    endtask

    task automatic chk(input string tag, input logic [2*L-1:0] act, input logic [2*L-1:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s op=%0d a=%b b=%b actual=%b expected=%b", tag, op_sel, a_i, b_i, act, exp);
        end
    endtask

    // monitor: pop one expected item per cycle, compare mid-cycle
    initial begin
        forever begin
            @(negedge clk);
            #(CLK_PER/4);
            if (sb.size() > 0) begin
                item_t it;
                it = sb.pop_front();
                chk(it.ytag, y_o, it.y);
                chk("R7 def", {{L{1'b0}}, def_o}, {{L{1'b0}}, it.d});
                chk("R7 bit", {{L{1'b0}}, bit_o}, {{L{1'b0}}, it.b});
                chk(it.ctag, cell_o, it.c);
            end
        end
    end

    initial begin
        #(CLK_PER * 2000);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R10 checked on the first item; R12: lane 1 gets the operands swapped
        for (int op = 0; op < 4; op++)
            for (int x = 0; x < 4; x++)
                for (int z = 0; z < 4; z++) begin
                    step(3'(op), {2'(z), 2'(x)}, {2'(x), 2'(z)});
                    ctag_g = "R9";
                end
        // R11: unused select codes
        step(3'd5, 4'b0100, 4'b0001);
        step(3'd6, 4'b1000, 4'b0010);
        step(3'd7, 4'b0000, 4'b0101);
        // R8: load high on lane 1, low on lane 0
        ctag_g = "R8";
        step(3'd4, 4'b0100, 4'b0000);
        step(3'd4, 4'b1010, 4'b0000);   // R9: floating input, checks load result
        ctag_g = "R9";
        step(3'd2, 4'b0011, 4'b0011);   // R9: other select, input ignored
        step(3'd4, 4'b1011, 4'b0000);   // lane 0 loads unknown, lane 1 floats
        ctag_g = "R8";
        step(3'd2, 4'b0000, 4'b0000);
        step(3'd4, 4'b0001, 4'b0000);
        step(3'd0, 4'b0000, 4'b0000);
        wait (sb.size() == 0);
        @(negedge clk);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule